// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

This block is an 8-bit up-counter. A free-running prescaler clocks it at one of eight fixed ratios of the system clock. Software picks one of two roles. In the interval role, every counter wrap raises an interrupt request. In the watchdog role, a wrap sends a one-cycle internal reset request, but only while an external reset-enable input is high.

The CPU sees two byte-wide registers through a small read/write port. The control/status byte holds a sticky overflow flag, the mode select, the run enable and a 3-bit ratio select. The second register is the counter itself. Both registers are write-protected: the upper byte of each 16-bit write word must carry the key that belongs to the target register.

The flag cannot be cleared by accident. A read must first see it set, and a later write of zero to the flag bit then clears it. A wrap that lands on the same cycle as the clearing write keeps the flag set.

Top module: `wdog_interval_timer`

## Requirements
- R1: After reset, the control/status byte reads 0x18, the counter reads 0x00, and `irq` and `wdog_rst_req` are low.
- R2: Control bits [2:0] select how many system clocks make one counter step. Codes 0 to 7 give 2, 64, 128, 512, 2048, 8192, 32768 and 131072 clocks in that order.
- R3: While the run bit (control bit 5) is 0, the counter is held at 0x00, and writes to the counter have no effect.
- R4: When the running counter wraps from 0xFF to 0x00, the flag (control bit 7) becomes 1. The one exception is R6's firing case.
- R5: While the mode bit (control bit 6) is 0, `irq` is high exactly while the flag is 1. While the mode bit is 1, `irq` stays low.
- R6: With the mode bit at 1, a wrap drives `wdog_rst_req` high for exactly one cycle if `rst_ena` is 1, and the flag reads 0 afterwards. If `rst_ena` is 0, no pulse appears and the flag is set.
- R7: A write of 0 to bit 7 clears the flag only if an earlier read of the control byte saw the flag at 1. A write of 1 to bit 7 never changes the flag.
- R8: Any write between that read and the clearing write cancels the pending clear.
- R9: A wrap in the same cycle as a clearing write wins: the flag stays 1.
- R10: Control bits 4 and 3 always read 1, and writes to them are ignored.
- R11: `reg_sel` 0 addresses the control byte and 1 addresses the counter. A write takes effect only if `wr_data[15:8]` is 0xA5 for the control byte or 0x5A for the counter; any other key leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_ena | input | 1 | Allows the reset request in watchdog mode |
| reg_sel | input | 1 | Register select: 0 control/status, 1 counter |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (arms the flag clear) |
| wr_data | input | 16 | Key in [15:8], value in [7:0] |
| rd_data | output | 8 | Selected register contents |
| irq | output | 1 | Interval interrupt request |
| wdog_rst_req | output | 1 | One-cycle internal reset request |

## Verification
The ratio select is driven through codes 0 to 6. For each code, the bench times the gap between two counter steps, so a tap moved by even one bit shows up as a wrong gap.

Wraps are produced in both modes and with `rst_ena` at both levels. This separates the interrupt path, the reset pulse and the automatic flag clear.

The clear handshake is tried four ways: with no prior read, with a write of 1, with an intervening write, and with the clearing write timed onto a wrap. Each of these differs from a plain clear in whether the flag survives.

Writes with foreign keys, writes while stopped, and writes to the fixed bits show whether protected state can be changed.

// File: rtl/wdit_pkg.sv
package wdit_pkg;

   localparam int SEL_W   = 3;
   localparam int NUM_SEL = 1 << SEL_W;

   typedef enum logic {
      SEL_CTRL  = 1'b0,
      SEL_COUNT = 1'b1
   } reg_sel_e;

   // prescaler bit whose rising transition yields a step for each ratio code
   function automatic int tap_bit(input int code);
      case (code)
         0:       return 0;
         1:       return 5;
         2:       return 6;
         3:       return 8;
         4:       return 10;
         5:       return 12;
         6:       return 14;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/wdit_prescaler.sv
module wdit_prescaler
   import wdit_pkg::*;
#(
   parameter int PRE_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] cks,
   output logic             tick
);

   if (PRE_W <= tap_bit(NUM_SEL - 1)) begin : g_bad_width
      $error("prescaler too narrow for the slowest tap");
   end

   logic [PRE_W-1:0]   pre_q;
   logic [NUM_SEL-1:0] tap_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   for (genvar t = 0; t < NUM_SEL; t++) begin : g_tap
      localparam int B = tap_bit(t);
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= pre_q[B];
      end
      assign tap_rise[t] = pre_q[B] & ~prev_q;
   end

   assign tick = tap_rise[cks];

   // R2
   tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tap_rise));

   // R2
   fast_tap_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap_rise[0] |=> !tap_rise[0]);

endmodule

// File: rtl/wdit_counter.sv
module wdit_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);

   localparam logic [CNT_W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (!run) count <= '0;
      else if (load) count <= load_val;
      else if (tick) count <= count + 1'b1;
   end

   assign wrap = run & ~load & tick & (count == TOP);

   // R3
   halt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> count == '0);

   // R4
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> count == '0);

endmodule

// File: rtl/wdit_ctrl.sv
module wdit_ctrl
   import wdit_pkg::*;
#(
   parameter int         DATA_W   = 8,
   parameter int         KEY_W    = 8,
   parameter logic [7:0] KEY_CTRL = 8'hA5,
   parameter logic [7:0] KEY_CNT  = 8'h5A
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rst_ena,
   input  logic                    reg_sel,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [KEY_W+DATA_W-1:0] wr_data,
   input  logic                    wrap,
   output logic [SEL_W-1:0]        cks,
   output logic                    run,
   output logic                    cnt_load,
   output logic [DATA_W-1:0]       ctrl_byte,
   output logic                    irq,
   output logic                    wdog_rst_req
);

   if (DATA_W != 8 || KEY_W != 8) begin : g_bad_layout
      $error("control byte layout needs 8-bit data and key");
   end

   logic             flag_q, wdog_q, armed_q;
   logic             ctrl_wr, clr_req, wd_fire;
   logic [KEY_W-1:0] key;

   assign key      = wr_data[KEY_W+DATA_W-1:DATA_W];
   assign ctrl_wr  = wr_en & (reg_sel == SEL_CTRL)  & (key == KEY_CTRL[KEY_W-1:0]);
   assign cnt_load = wr_en & (reg_sel == SEL_COUNT) & (key == KEY_CNT[KEY_W-1:0]);
   assign clr_req  = ctrl_wr & armed_q & ~wr_data[7];
   assign wd_fire  = wrap & wdog_q & rst_ena;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdog_q <= 1'b0;
         run    <= 1'b0;
         cks    <= '0;
      end else if (ctrl_wr) begin
         wdog_q <= wr_data[6];
         run    <= wr_data[5];
         cks    <= wr_data[SEL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    armed_q <= 1'b0;
      else if (wr_en)                                armed_q <= 1'b0;
      else if (rd_en && reg_sel == SEL_CTRL && flag_q) armed_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (wd_fire) flag_q <= 1'b0;
      else if (wrap)    flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wdog_rst_req <= 1'b0;
      else        wdog_rst_req <= wd_fire;
   end

   assign irq       = flag_q & ~wdog_q;
   assign ctrl_byte = {flag_q, wdog_q, run, 2'b11, cks};

   // R4
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !(wdog_q && rst_ena)) |=> flag_q);

   // R7
   flag_clear_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> ($past(armed_q) || $past(wdog_rst_req) || wdog_rst_req));

   // R6
   rst_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst_req |=> !wdog_rst_req);

   // R6
   rst_flag_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst_req |-> !flag_q);

   // R11
   sel_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cks) |-> $past(wr_en && reg_sel == SEL_CTRL && key == KEY_CTRL[KEY_W-1:0]));

endmodule

// File: rtl/wdog_interval_timer.sv
module wdog_interval_timer
   import wdit_pkg::*;
#(
   parameter int         CNT_W    = 8,
   parameter int         PRE_W    = 17,
   parameter logic [7:0] KEY_CTRL = 8'hA5,
   parameter logic [7:0] KEY_CNT  = 8'h5A
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rst_ena,
   input  logic        reg_sel,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [15:0] wr_data,
   output logic [7:0]  rd_data,
   output logic        irq,
   output logic        wdog_rst_req
);

   localparam int DATA_W = 8;

   if (CNT_W != DATA_W) begin : g_bad_cnt
      $error("counter width must match the register byte");
   end

   logic             tick, run, cnt_load, wrap;
   logic [SEL_W-1:0] cks;
   logic [CNT_W-1:0] count;
   logic [7:0]       ctrl_byte;

   wdit_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk (clk),
      .rst_n (rst_n),
      .cks (cks),
      .tick (tick)
   );

   wdit_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk),
      .rst_n (rst_n),
      .run (run),
      .tick (tick),
      .load (cnt_load),
      .load_val (wr_data[CNT_W-1:0]),
      .count (count),
      .wrap (wrap)
   );

   wdit_ctrl #(
      .DATA_W (DATA_W),
      .KEY_W (8),
      .KEY_CTRL (KEY_CTRL),
      .KEY_CNT (KEY_CNT)
   ) u_ctl (
      .clk (clk),
      .rst_n (rst_n),
      .rst_ena (rst_ena),
      .reg_sel (reg_sel),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .wr_data (wr_data),
      .wrap (wrap),
      .cks (cks),
      .run (run),
      .cnt_load (cnt_load),
      .ctrl_byte (ctrl_byte),
      .irq (irq),
      .wdog_rst_req (wdog_rst_req)
   );

   assign rd_data = (reg_sel == SEL_COUNT) ? count : ctrl_byte;

   // R5
   irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !ctrl_byte[6]);

   // R10
   fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_byte[4:3] == 2'b11);

endmodule

// File: tb/sim_wdog_interval_timer.sv
module sim_wdog_interval_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_ena = 1'b0;
   logic        reg_sel = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [7:0]  rd_data;
   logic        irq, wdog_rst_req;

   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   localparam logic [7:0] KC = 8'hA5;
   localparam logic [7:0] KN = 8'h5A;

   // stimulus: ratio code; expected: clocks per counter step
   localparam int NV = 7;
   localparam logic [2:0] V_CODE [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
   localparam int         V_DIV  [NV] = '{2, 64, 128, 512, 2048, 8192, 32768};

   always #10 clk = ~clk;

   wdog_interval_timer u0 (
      .clk (clk), .rst_n (rst_n), .rst_ena (rst_ena), .reg_sel (reg_sel),
      .wr_en (wr_en), .rd_en (rd_en), .wr_data (wr_data), .rd_data (rd_data),
      .irq (irq), .wdog_rst_req (wdog_rst_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic s, input logic [7:0] k, input logic [7:0] d);
      @(negedge clk);
      reg_sel = s; wr_en = 1'b1; wr_data = {k, d};
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic s, output logic [7:0] v);
      @(negedge clk);
      reg_sel = s; rd_en = 1'b1;
      #1 v = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_step(output int n);
      logic [7:0] p;
      reg_sel = 1'b1;
      #1 p = rd_data;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (rd_data == p);
   endtask

   initial begin
      repeat (160000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int n, p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      reg_sel = 1'b0; #1 chk("R1 ctrl", rd_data, 8'h18);
      reg_sel = 1'b1; #1 chk("R1 count", rd_data, 8'h00);
      chk("R1 irq", irq, 1'b0);
      chk("R1 rst_req", wdog_rst_req, 1'b0);

      // R11 wrong keys on control byte
      wr(1'b0, 8'h00, 8'h27); rd(1'b0, v); chk("R11 ctrl no key", v, 8'h18);
      wr(1'b0, KN,    8'h27); rd(1'b0, v); chk("R11 ctrl count key", v, 8'h18);
      // R10 fixed bits
      wr(1'b0, KC, 8'h07); rd(1'b0, v); chk("R10 bits 4:3", v, 8'h1F);

      // R11 counter key (slowest ratio, no step in this window)
      wr(1'b0, KC, 8'h27);
      wr(1'b1, KC, 8'h40); rd(1'b1, v); chk("R11 count wrong key", v, 8'h00);
      wr(1'b1, KN, 8'h40); rd(1'b1, v); chk("R11 count load", v, 8'h40);

      // R3 stopped counter
      wr(1'b0, KC, 8'h07); rd(1'b1, v); chk("R3 stop clears", v, 8'h00);
      wr(1'b1, KN, 8'h33); rd(1'b1, v); chk("R3 load ignored", v, 8'h00);
      repeat (100) @(negedge clk);
      reg_sel = 1'b1; #1 chk("R3 held", rd_data, 8'h00);

      // R2 vector table
      for (int i = 0; i < NV; i++) begin
         wr(1'b0, KC, {5'b00100, V_CODE[i]});
         wait_step(n);
         wait_step(n);
         chk($sformatf("R2 code %0d", V_CODE[i]), n, V_DIV[i]);
      end

      // clear whatever flag the table run left, then stop
      rd(1'b0, v);
      wr(1'b0, KC, 8'h00);
      rd(1'b0, v); chk("R7 clear after read", v, 8'h18);

      // R4 / R5 interval overflow
      wr(1'b0, KC, 8'h20);
      wr(1'b1, KN, 8'hFE);
      repeat (8) @(negedge clk);
      chk("R5 irq on wrap", irq, 1'b1);
      wr(1'b0, KC, 8'h20);
      chk("R7 no read no clear", irq, 1'b1);
      rd(1'b0, v); chk("R4 flag set", v, 8'hB8);
      wr(1'b0, KC, 8'hA0);
      chk("R7 write one no effect", irq, 1'b1);
      wr(1'b0, KC, 8'h20);
      chk("R8 disarmed by write", irq, 1'b1);
      rd(1'b0, v);
      wr(1'b0, KC, 8'h20);
      chk("R7 handshake clears", irq, 1'b0);
      rd(1'b0, v); chk("R7 flag read", v, 8'h38);

      // R9 wrap coincides with clearing write
      wr(1'b1, KN, 8'hFE);
      repeat (8) @(negedge clk);
      wr(1'b1, KN, 8'hF0);
      rd(1'b0, v);
      reg_sel = 1'b1;
      do @(negedge clk); while (rd_data != 8'hFF);
      wr(1'b0, KC, 8'h20);
      chk("R9 wrap beats clear", irq, 1'b1);

      // R6 watchdog mode, reset disabled
      rd(1'b0, v);
      wr(1'b0, KC, 8'h60);
      p = 0;
      wr(1'b1, KN, 8'hFE);
      repeat (10) begin @(negedge clk); if (wdog_rst_req) p++; end
      chk("R6 no pulse when disabled", p, 0);
      chk("R5 irq low in watchdog", irq, 1'b0);
      rd(1'b0, v); chk("R6 flag set when disabled", v, 8'hF8);

      // R6 watchdog mode, reset enabled
      wr(1'b0, KC, 8'h60);
      rd(1'b0, v);
      wr(1'b0, KC, 8'h60);
      rst_ena = 1'b1;
      p = 0;
      wr(1'b1, KN, 8'hFE);
      repeat (10) begin @(negedge clk); if (wdog_rst_req) p++; end
      chk("R6 single pulse", p, 1);
      rd(1'b0, v); chk("R6 flag auto cleared", v, 8'h78);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule